// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter

This block is a 4-bit synchronous up-counter meant to be chained into wider counters. It clears to zero as soon as its active-low clear input goes low, loads a preset value on a clock edge when its active-low load input is low, and otherwise counts up or holds. Two enable inputs control counting. The enable that also gates the carry output, here called the chain enable, is the one that carries the look-ahead carry from one stage to the next.

The carry output is high when the count is all ones and the chain enable is high. It is combinational from the register and that one input. To build a wider counter, wire a stage's carry output to the chain enable of the next more significant stage and share the clock between all stages. Every bit of the chain then changes on the same edge. The clear input goes low without waiting for a clock. Its release passes through an internal synchronizer, so the first two rising edges after release leave the count at zero.

Top module: `casc_counter4`

## Requirements
- R1: The count is a WIDTH-bit (default 4) unsigned value. When it counts up from its maximum (15), it wraps to 0.
- R2: While clear_n is low, count is 0 and carry_out is 0. The count is forced to 0 without any clock edge.
- R3: After clear_n returns high, the first two rising edges leave the count at 0. The third rising edge is the first one that can load or count.
- R4: When load_n is low at a rising edge, count takes the value of din on that edge, whatever the levels of cnt_en and chain_en.
- R5: When load_n is high and both cnt_en and chain_en are high at a rising edge, count goes up by one.
- R6: When load_n is high and either cnt_en or chain_en is low at a rising edge, count keeps its value.
- R7: carry_out is 1 exactly when count equals 15 and chain_en is 1. cnt_en has no effect on it.
- R8: A load of 15 with chain_en high raises carry_out directly after that edge. carry_out falls after the wrap to 0, or after a load of any other value.
- R9: With a shared clock, the low stage's carry_out wired to the high stage's chain_en, and one enable driving both stages' cnt_en and the low stage's chain_en, two stages form an 8-bit counter. That counter steps from 0x0F to 0x10, and from 0xFF to 0x00, on a single edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Active-low clear. Asserts without a clock; release is synchronized |
| load_n | input | 1 | Active-low synchronous load of din |
| din | input | WIDTH | Preset value to load |
| cnt_en | input | 1 | Count enable that does not gate the carry |
| chain_en | input | 1 | Count enable that also gates carry_out |
| count | output | WIDTH | Current count |
| carry_out | output | 1 | High when count is all ones and chain_en is high |

## Verification
Load and count can be requested in the same cycle: load_n low with both enables high. The bench provokes this both in a directed case and through random stimulus in which all four control inputs vary freely. Every such cycle is judged by a reference function that ranks load above count, so the count must equal din and never the incremented value. A second collision is between the carry output and the terminal count. The bench holds count at 15 while cnt_en is low or chain_en is low, and checks that the carry follows only chain_en.

// File: rtl/casc_ctr_pkg.sv
package casc_ctr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2
  } ctr_op_e;
endpackage

// File: rtl/ctr_rst_sync.sv
module ctr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_out
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= {sync_q[LAST-1:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_out = sync_q[LAST];
endmodule

// File: rtl/ctr_next_state.sv
module ctr_next_state
  import casc_ctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] count_q,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             cnt_en,
  input  logic             chain_en,
  output ctr_op_e          op,
  output logic [WIDTH-1:0] count_d
);
  always_comb begin
    if (!load_n)                  op = OP_LOAD;
    else if (cnt_en && chain_en)  op = OP_COUNT;
    else                          op = OP_HOLD;
  end

  always_comb begin
    unique case (op)
      OP_LOAD:  count_d = din;
      OP_COUNT: count_d = count_q + WIDTH'(1);
      default:  count_d = count_q;
    endcase
  end
endmodule

// File: rtl/ctr_term_detect.sv
module ctr_term_detect #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] count_q,
  input  logic             chain_en,
  output logic             carry
);
  logic [WIDTH:0] all_ones;

  assign all_ones[0] = 1'b1;
  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_and
      assign all_ones[b+1] = all_ones[b] & count_q[b];
    end
  endgenerate

  assign carry = all_ones[WIDTH] & chain_en;
endmodule

// File: rtl/casc_counter4.sv
module casc_counter4
  import casc_ctr_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             cnt_en,
  input  logic             chain_en,
  output logic [WIDTH-1:0] count,
  output logic             carry_out
);
  localparam logic [WIDTH-1:0] MAX_VAL = {WIDTH{1'b1}};

  logic             rst_n_int;
  ctr_op_e          op;
  logic [WIDTH-1:0] count_d;
  logic [WIDTH-1:0] count_q;
  logic             upd_en;

  ctr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk       (clk),
    .arst_n    (clear_n),
    .rst_n_out (rst_n_int)
  );

  ctr_next_state #(.WIDTH(WIDTH)) u_next (
    .count_q  (count_q),
    .load_n   (load_n),
    .din      (din),
    .cnt_en   (cnt_en),
    .chain_en (chain_en),
    .op       (op),
    .count_d  (count_d)
  );

  assign upd_en = (op != OP_HOLD);

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)  count_q <= '0;
    else if (upd_en) count_q <= count_d;
  end

  ctr_term_detect #(.WIDTH(WIDTH)) u_term (
    .count_q  (count_q),
    .chain_en (chain_en),
    .carry    (carry_out)
  );

  assign count = count_q;

  // R4
  load_takes_din_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !load_n |=> count == $past(din));

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (load_n && cnt_en && chain_en) |=> count == $past(count) + WIDTH'(1));

  // R6
  hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (load_n && !(cnt_en && chain_en)) |=> $stable(count));

  // R1
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (carry_out && load_n && cnt_en) |=> count == '0);

  // R8
  load_max_carry_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!load_n && din == MAX_VAL) |=> (carry_out == chain_en));
endmodule

// File: tb/casc_counter4_tb_top.sv
module casc_counter4_tb_top;
  localparam int W = 4;

  logic clk;
  logic clear_n;
  logic load_n;
  logic [W-1:0] din;
  logic cnt_en;
  logic chain_en;
  logic [W-1:0] count;
  logic carry_out;

  logic cas_load_n;
  logic [7:0] cas_din;
  logic cas_en;
  logic [3:0] q_lo, q_hi;
  logic c_lo, c_hi;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [W-1:0] exp_cnt;

  casc_counter4 dut_i (
    .clk(clk), .clear_n(clear_n), .load_n(load_n), .din(din),
    .cnt_en(cnt_en), .chain_en(chain_en), .count(count), .carry_out(carry_out)
  );

  casc_counter4 st_lo (
    .clk(clk), .clear_n(clear_n), .load_n(cas_load_n), .din(cas_din[3:0]),
    .cnt_en(cas_en), .chain_en(cas_en), .count(q_lo), .carry_out(c_lo)
  );

  casc_counter4 st_hi (
    .clk(clk), .clear_n(clear_n), .load_n(cas_load_n), .din(cas_din[7:4]),
    .cnt_en(cas_en), .chain_en(c_lo), .count(q_hi), .carry_out(c_hi)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [W-1:0] ref_next(logic [W-1:0] cur, logic ld_n,
                                            logic [W-1:0] d, logic a, logic b);
    if (!ld_n)      return d;
    else if (a && b) return cur + W'(1);
    else            return cur;
  endfunction

  function automatic logic ref_carry(logic [W-1:0] cur, logic b);
    return (cur == {W{1'b1}}) && b;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // one cycle on dut_i with model update and checks of count and carry
  task automatic cyc(logic ld_n, logic [W-1:0] d, logic a, logic b, string req);
    @(negedge clk);
    load_n = ld_n; din = d; cnt_en = a; chain_en = b;
    @(posedge clk);
    #1;
    exp_cnt = ref_next(exp_cnt, ld_n, d, a, b);
    check(count == exp_cnt, req, count, exp_cnt);
    check(carry_out == ref_carry(exp_cnt, b), {req, "/R7"}, carry_out, ref_carry(exp_cnt, b));
  endtask

  task automatic cas_cyc(logic ld_n, logic [7:0] d, logic en, logic [7:0] expv, string req);
    @(negedge clk);
    cas_load_n = ld_n; cas_din = d; cas_en = en;
    @(posedge clk);
    #1;
    check({q_hi, q_lo} == expv, req, {q_hi, q_lo}, expv);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    clear_n = 1'b0; load_n = 1'b1; din = '0; cnt_en = 1'b1; chain_en = 1'b1;
    cas_load_n = 1'b1; cas_din = '0; cas_en = 1'b0;
    exp_cnt = '0;
    repeat (3) @(posedge clk);
    #1;
    // R2 reset state
    check(count == 0, "R2", count, 0);
    check(carry_out == 1'b0, "R2", carry_out, 0);

    // R3 release: two idle edges, then counting
    @(negedge clk);
    clear_n = 1'b1;
    @(posedge clk); #1;
    check(count == 0, "R3", count, 0);
    @(posedge clk); #1;
    check(count == 0, "R3", count, 0);
    @(posedge clk); #1;
    check(count == 1, "R3", count, 1);
    exp_cnt = 1;

    // R4 load with both enables low
    cyc(1'b0, 4'd14, 1'b0, 1'b0, "R4");
    cyc(1'b1, 4'd0, 1'b1, 1'b1, "R5");
    // R7 at 15: carry follows chain_en only
    cyc(1'b1, 4'd0, 1'b0, 1'b1, "R6");
    check(carry_out == 1'b1, "R7", carry_out, 1);
    cyc(1'b1, 4'd0, 1'b1, 1'b0, "R6");
    check(carry_out == 1'b0, "R7", carry_out, 0);
    // R1 wrap
    cyc(1'b1, 4'd0, 1'b1, 1'b1, "R1");
    check(count == 0, "R1", count, 0);
    // R8 load 15 with chain high
    cyc(1'b0, 4'd15, 1'b0, 1'b1, "R8");
    check(carry_out == 1'b1, "R8", carry_out, 1);
    cyc(1'b0, 4'd5, 1'b0, 1'b1, "R8");
    check(carry_out == 1'b0, "R8", carry_out, 0);
    // R4 load beats count
    cyc(1'b0, 4'd9, 1'b1, 1'b1, "R4");
    check(count == 9, "R4", count, 9);

    // R2 asynchronous clear between edges
    @(negedge clk);
    load_n = 1'b1; cnt_en = 1'b0; chain_en = 1'b1;
    #0.5;
    clear_n = 1'b0;
    #0.5;
    check(count == 0, "R2", count, 0);
    check(carry_out == 1'b0, "R2", carry_out, 0);
    @(negedge clk);
    clear_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    exp_cnt = '0;
    check(count == 0, "R2", count, 0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic ld_n, a, b;
      logic [W-1:0] d;
      ld_n = ($urandom_range(0, 7) != 0);
      a    = ($urandom_range(0, 3) != 0);
      b    = ($urandom_range(0, 3) != 0);
      d    = W'($urandom_range(0, 15));
      cyc(ld_n, d, a, b, "R5");
    end

    // R9 cascade
    cas_cyc(1'b0, 8'h0E, 1'b0, 8'h0E, "R9");
    cas_cyc(1'b1, 8'h00, 1'b1, 8'h0F, "R9");
    cas_cyc(1'b1, 8'h00, 1'b1, 8'h10, "R9");
    cas_cyc(1'b0, 8'hFF, 1'b0, 8'hFF, "R9");
    check(c_hi == 1'b0, "R9", c_hi, 0);
    cas_cyc(1'b1, 8'h00, 1'b1, 8'h00, "R9");
    cas_cyc(1'b1, 8'h00, 1'b0, 8'h00, "R9");

    finish_run();
  end
endmodule